// File: doc/BRIEF.md
# Region Access Permission Checker

This block guards an 8 MB window of physical memory that begins at 0x08000000. The window is cut into thirty-two 256 KB regions. Each region carries four enable bits, one for each pairing of privilege (kernel or user) and direction (read or write). Every access presented on the access port is tested against the bits of the region it falls in. The verdict comes back in the same cycle. Addresses outside the window are not checked.

Software loads the enables through a small 32-bit register port. Four permission words each hold eight regions. A further status word and a captured-address word let software inspect the first access that was refused. A refused access raises a sticky flag and records the address, the direction and the privilege of that access. Further refusals leave the record alone until software clears the flag.

Top module: `region_perm_guard`

## Requirements
- R1: After reset every permission bit reads as 1, the violation flag is 0, the status word reads 0 and every access is allowed.
- R2: The permission words sit at byte offsets 0x0, 0x4, 0x8 and 0xC of the register port. Each is a full 32-bit read/write word. A write whose two low offset bits are not zero is ignored.
- R3: For an address inside the window, the region index is bits [22:18] of (address − 0x08000000). The upper two index bits pick the permission word. The lower three bits n pick the nibble at bits [4n+3:4n] of that word.
- R4: Within the nibble, bit 3 enables kernel writes, bit 2 kernel reads, bit 1 user writes and bit 0 user reads. An access inside the window is allowed exactly when the bit for its privilege and direction is 1.
- R5: Any address below 0x08000000 or at or above 0x08800000 is allowed whatever the permissions.
- R6: The allow output follows the address, direction, privilege and stored permissions in the same cycle, with no register on the path.
- R7: A refused access with the valid strobe high, seen while the flag is clear, sets the flag at the next clock edge and records the access. The status word at offset 0x10 reads bit 0 = flag, bit 1 = recorded write, bit 2 = recorded user. The recorded address reads at offset 0x14. A refused lookup with the valid strobe low records nothing.
- R8: While the flag is set, further refused accesses change neither the flag nor the recorded address and attributes.
- R9: A write to offset 0x10 with bit 0 set clears the flag. A write there with bit 0 clear leaves the flag as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| acc_valid | input | 1 | Access is real and may be recorded if refused |
| acc_addr | input | 32 | Physical address of the access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_user | input | 1 | 1 = user mode, 0 = kernel mode |
| acc_allow | output | 1 | Access permitted |
| viol_flag | output | 1 | Sticky refused-access flag |

## Verification
On every cycle the assertions check four things. Addresses outside the window always pass. A valid refusal with the flag clear records its address. The flag and the record stay frozen while set until a clearing write. No other event raises the flag. The exact mapping from address to word, nibble and enable bit, the register readback, and the effect of each status write can only be shown by the bench. It sweeps every region and access kind against a model of the permission words, and it walks the window edges and a sequence of refusals and clears.

// File: rtl/perm_guard_pkg.sv
package perm_guard_pkg;

    // register slots (word index within the config port) beyond the permission words
    localparam int unsigned SLOT_STATUS  = 4;
    localparam int unsigned SLOT_CAPADDR = 5;

    // enables per region
    localparam int unsigned NIB_W = 4;

    // position of the enable inside a region nibble: kernel above user, write above read
    function automatic logic [1:0] enable_pos(input logic is_write, input logic is_user);
        return {~is_user, is_write};
    endfunction

endpackage

// File: rtl/perm_table.sv
module perm_table #(
    parameter int unsigned NUM_WORDS = 4,
    parameter int unsigned DATA_W    = 32,
    localparam int unsigned WSEL_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [WSEL_W-1:0]                 wr_sel,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [NUM_WORDS-1:0][DATA_W-1:0]  words
);

    typedef struct packed {
        logic [NUM_WORDS-1:0][DATA_W-1:0] words;
    } table_t;

    table_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.words[wr_sel] = wr_data;
        end
    end

    // every enable starts open so the window is unrestricted until loaded
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign words = st_q.words;

endmodule

// File: rtl/perm_lookup.sv
module perm_lookup
    import perm_guard_pkg::*;
#(
    parameter int unsigned              ADDR_W       = 32,
    parameter logic [ADDR_W-1:0]        WIN_BASE     = 32'h0800_0000,
    parameter int unsigned              REGION_SHIFT = 18,
    parameter int unsigned              NUM_WORDS    = 4,
    parameter int unsigned              NIB_PER_WORD = 8,
    localparam int unsigned             DATA_W       = NIB_PER_WORD * NIB_W
) (
    input  logic [NUM_WORDS-1:0][DATA_W-1:0] words,
    input  logic [ADDR_W-1:0]                acc_addr,
    input  logic                             acc_write,
    input  logic                             acc_user,
    output logic                             allow
);

    localparam int unsigned REGIONS = NUM_WORDS * NIB_PER_WORD;
    localparam int unsigned WSEL_W  = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int unsigned NSEL_W  = (NIB_PER_WORD > 1) ? $clog2(NIB_PER_WORD) : 1;
    localparam int unsigned IDX_W   = WSEL_W + NSEL_W;
    localparam logic [ADDR_W-1:0] WIN_SPAN = ADDR_W'(REGIONS) << REGION_SHIFT;

    logic [ADDR_W-1:0]               offset;
    logic                            in_window;
    logic [IDX_W-1:0]                idx;
    logic [WSEL_W-1:0]               wsel;
    logic [NSEL_W-1:0]               nsel;
    logic [NUM_WORDS-1:0][NIB_W-1:0] word_nib;
    logic [NIB_W-1:0]                sel_nib;
    logic                            en_bit;

    // a single subtract-and-compare tolerates any base, aligned or not
    assign offset    = acc_addr - WIN_BASE;
    assign in_window = offset < WIN_SPAN;
    assign idx       = offset[REGION_SHIFT +: IDX_W];
    assign wsel      = idx[IDX_W-1 -: WSEL_W];
    assign nsel      = idx[NSEL_W-1:0];

    // nibble select runs in parallel across all words, word select follows
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        assign word_nib[g] = words[g][{nsel, 2'b00} +: NIB_W];
    end

    assign sel_nib = word_nib[wsel];
    assign en_bit  = sel_nib[enable_pos(acc_write, acc_user)];
    assign allow   = !in_window || en_bit;

endmodule

// File: rtl/viol_latch.sv
module viol_latch #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deny,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_user,
    input  logic              clr,
    output logic              flag,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              cap_write,
    output logic              cap_user
);

    typedef struct packed {
        logic              flag;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              user;
    } rec_t;

    rec_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.flag) begin
            // record frozen; only software can reopen it
            if (clr) begin
                st_d.flag = 1'b0;
            end
        end else if (deny) begin
            st_d.flag  = 1'b1;
            st_d.addr  = acc_addr;
            st_d.write = acc_write;
            st_d.user  = acc_user;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag      = st_q.flag;
    assign cap_addr  = st_q.addr;
    assign cap_write = st_q.write;
    assign cap_user  = st_q.user;

endmodule

// File: rtl/region_perm_guard.sv
module region_perm_guard
    import perm_guard_pkg::*;
#(
    parameter int unsigned        ADDR_W       = 32,
    parameter logic [ADDR_W-1:0]  WIN_BASE     = 32'h0800_0000,
    parameter int unsigned        REGION_SHIFT = 18,
    parameter int unsigned        NUM_WORDS    = 4,
    parameter int unsigned        NIB_PER_WORD = 8,
    parameter int unsigned        CFG_AW       = 5,
    localparam int unsigned       DATA_W       = NIB_PER_WORD * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_user,
    output logic              acc_allow,
    output logic              viol_flag
);

    localparam int unsigned WSEL_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int unsigned SLOT_W = CFG_AW - 2;

    logic [SLOT_W-1:0]               slot;
    logic                            aligned;
    logic                            perm_wr;
    logic                            flag_clr;
    logic [NUM_WORDS-1:0][DATA_W-1:0] perm_words;
    logic                            deny;
    logic [ADDR_W-1:0]               cap_addr;
    logic                            cap_write;
    logic                            cap_user;

    // register port decode
    assign slot     = cfg_addr[CFG_AW-1:2];
    assign aligned  = (cfg_addr[1:0] == 2'b00);
    assign perm_wr  = cfg_wr_en && aligned && (slot < SLOT_W'(NUM_WORDS));
    assign flag_clr = cfg_wr_en && aligned && (slot == SLOT_W'(SLOT_STATUS)) && cfg_wdata[0];

    perm_table #(
        .NUM_WORDS (NUM_WORDS),
        .DATA_W    (DATA_W)
    ) i_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (perm_wr),
        .wr_sel  (slot[WSEL_W-1:0]),
        .wr_data (cfg_wdata),
        .words   (perm_words)
    );

    perm_lookup #(
        .ADDR_W       (ADDR_W),
        .WIN_BASE     (WIN_BASE),
        .REGION_SHIFT (REGION_SHIFT),
        .NUM_WORDS    (NUM_WORDS),
        .NIB_PER_WORD (NIB_PER_WORD)
    ) i_lookup (
        .words     (perm_words),
        .acc_addr  (acc_addr),
        .acc_write (acc_write),
        .acc_user  (acc_user),
        .allow     (acc_allow)
    );

    assign deny = acc_valid && !acc_allow;

    viol_latch #(
        .ADDR_W (ADDR_W)
    ) i_viol (
        .clk       (clk),
        .rst_n     (rst_n),
        .deny      (deny),
        .acc_addr  (acc_addr),
        .acc_write (acc_write),
        .acc_user  (acc_user),
        .clr       (flag_clr),
        .flag      (viol_flag),
        .cap_addr  (cap_addr),
        .cap_write (cap_write),
        .cap_user  (cap_user)
    );

    // register readback
    always_comb begin
        cfg_rdata = '0;
        if (aligned) begin
            if (slot < SLOT_W'(NUM_WORDS)) begin
                cfg_rdata = perm_words[slot[WSEL_W-1:0]];
            end else if (slot == SLOT_W'(SLOT_STATUS)) begin
                cfg_rdata = {{(DATA_W-3){1'b0}}, cap_user, cap_write, viol_flag};
            end else if (slot == SLOT_W'(SLOT_CAPADDR)) begin
                cfg_rdata = DATA_W'(cap_addr);
            end
        end
    end

endmodule

// File: rtl/perm_guard_checker.sv
module perm_guard_checker
    import perm_guard_pkg::*;
#(
    parameter int unsigned       ADDR_W       = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE     = 32'h0800_0000,
    parameter int unsigned       REGION_SHIFT = 18,
    parameter int unsigned       NUM_WORDS    = 4,
    parameter int unsigned       NIB_PER_WORD = 8,
    parameter int unsigned       CFG_AW       = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic              cfg_wdata_b0,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_allow,
    input logic              viol_flag,
    input logic [ADDR_W-1:0] cap_addr
);

    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_WORDS * NIB_PER_WORD) << REGION_SHIFT;

    logic outside;
    logic sw_clear;
    logic refused;

    assign outside  = (acc_addr - WIN_BASE) >= SPAN;
    assign sw_clear = cfg_wr_en && (cfg_addr == CFG_AW'(SLOT_STATUS * 4)) && cfg_wdata_b0;
    assign refused  = acc_valid && !acc_allow;

    assert_outside_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        outside |-> acc_allow);

    assert_capture_on_deny_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (refused && !viol_flag) |=> (viol_flag && cap_addr == $past(acc_addr)));

    assert_no_spurious_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!viol_flag && !refused) |=> !viol_flag);

    assert_hold_record_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && !sw_clear) |=> (viol_flag && $stable(cap_addr)));

    assert_clear_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && sw_clear) |=> !viol_flag);

endmodule

bind region_perm_guard perm_guard_checker #(
    .ADDR_W       (ADDR_W),
    .WIN_BASE     (WIN_BASE),
    .REGION_SHIFT (REGION_SHIFT),
    .NUM_WORDS    (NUM_WORDS),
    .NIB_PER_WORD (NIB_PER_WORD),
    .CFG_AW       (CFG_AW)
) i_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_addr     (cfg_addr),
    .cfg_wdata_b0 (cfg_wdata[0]),
    .acc_valid    (acc_valid),
    .acc_addr     (acc_addr),
    .acc_allow    (acc_allow),
    .viol_flag    (viol_flag),
    .cap_addr     (cap_addr)
);

// File: tb/test_region_perm_guard.sv
`timescale 1ns/1ps
module test_region_perm_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        acc_user = 1'b0;
    logic        acc_allow;
    logic        viol_flag;

    int total = 0;
    int bad = 0;
    logic [31:0] model [4];

    always #4 clk = ~clk;

    region_perm_guard i_region_perm_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_en (cfg_wr_en),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_write (acc_write),
        .acc_user  (acc_user),
        .acc_allow (acc_allow),
        .viol_flag (viol_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (a[1:0] == 2'b00 && a[4:2] < 3'd4) model[a[3:2]] = d;
    endtask

    task automatic cfg_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    // allow sampled in the same cycle the access is driven; valid dropped a cycle later
    task automatic probe(input logic [31:0] a, input logic wr, input logic usr,
                         input logic vld, output logic ok);
        @(negedge clk);
        acc_addr  = a;
        acc_write = wr;
        acc_user  = usr;
        acc_valid = vld;
        #1;
        ok = acc_allow;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    function automatic logic exp_allow(input logic [31:0] a, input logic wr, input logic usr);
        logic [31:0] off;
        logic [4:0]  r;
        int          b;
        off = a - 32'h0800_0000;
        if (off >= 32'h0080_0000) return 1'b1;
        r = off[22:18];
        b = usr ? (wr ? 1 : 0) : (wr ? 3 : 2);
        return model[r[4:3]][r[2:0] * 4 + b];
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        logic ok;
        for (int w = 0; w < 4; w++) begin
            cfg_read(5'(w * 4), d);
            check("R1 reset permission word", d, 32'hFFFF_FFFF);
        end
        cfg_read(5'h10, d);
        check("R1 reset status", d, 32'h0);
        check("R1 reset flag pin", {31'b0, viol_flag}, 32'h0);
        probe(32'h0834_5678, 1'b1, 1'b1, 1'b1, ok);
        check("R1 user write allowed after reset", {31'b0, ok}, 32'h1);
    endtask

    task automatic t_regfile();
        logic [31:0] d;
        logic [31:0] pat [4];
        pat[0] = 32'h1234_5678; pat[1] = 32'h9ABC_DEF0;
        pat[2] = 32'h0F0F_A5A5; pat[3] = 32'hC3C3_3C3C;
        for (int w = 0; w < 4; w++) cfg_write(5'(w * 4), pat[w]);
        for (int w = 0; w < 4; w++) begin
            cfg_read(5'(w * 4), d);
            check("R2 permission word readback", d, pat[w]);
        end
        cfg_write(5'h05, 32'h0000_0000);
        cfg_read(5'h04, d);
        check("R2 misaligned write ignored", d, pat[1]);
    endtask

    task automatic sweep(input string tag);
        logic ok;
        for (int r = 0; r < 32; r++) begin
            for (int k = 0; k < 4; k++) begin
                logic [31:0] a;
                a = 32'h0800_0000 + (32'(r) << 18) + 32'(k * 32'h1_0404);
                probe(a, k[1], k[0], 1'b0, ok);
                check(tag, {31'b0, ok}, {31'b0, exp_allow(a, k[1], k[0])});
            end
        end
    endtask

    task automatic t_mapping();
        cfg_write(5'h00, 32'h8421_1248);
        cfg_write(5'h04, 32'h0000_000F);
        cfg_write(5'h08, 32'hF000_0000);
        cfg_write(5'h0C, 32'h6A59_C3E1);
        sweep("R3 R4 region and enable decode, pattern A");
        cfg_write(5'h00, 32'hEDB7_7BDE);
        cfg_write(5'h04, 32'h5A5A_A5A5);
        cfg_write(5'h08, 32'h0FF0_1E2D);
        cfg_write(5'h0C, 32'h3C96_87B4);
        sweep("R3 R4 region and enable decode, pattern B");
    endtask

    task automatic t_edges();
        logic ok;
        for (int w = 0; w < 4; w++) cfg_write(5'(w * 4), 32'h0);
        probe(32'h07FF_FFFF, 1'b1, 1'b1, 1'b1, ok);
        check("R5 just below window allowed", {31'b0, ok}, 32'h1);
        probe(32'h0880_0000, 1'b1, 1'b1, 1'b1, ok);
        check("R5 just above window allowed", {31'b0, ok}, 32'h1);
        probe(32'h0000_1000, 1'b0, 1'b0, 1'b1, ok);
        check("R5 far below window allowed", {31'b0, ok}, 32'h1);
        check("R5 outside accesses leave flag clear", {31'b0, viol_flag}, 32'h0);
        probe(32'h0800_0000, 1'b0, 1'b0, 1'b0, ok);
        check("R4 first window byte refused", {31'b0, ok}, 32'h0);
        probe(32'h087F_FFFF, 1'b0, 1'b1, 1'b0, ok);
        check("R4 last window byte refused", {31'b0, ok}, 32'h0);
        cfg_write(5'h0C, 32'h1000_0000);
        probe(32'h087F_FFFF, 1'b0, 1'b1, 1'b0, ok);
        check("R6 allow follows new permission at once", {31'b0, ok}, 32'h1);
        cfg_write(5'h0C, 32'h0);
    endtask

    task automatic t_capture();
        logic [31:0] d;
        logic ok;
        probe(32'h0812_3456, 1'b1, 1'b1, 1'b0, ok);
        check("R4 refused lookup", {31'b0, ok}, 32'h0);
        cfg_read(5'h10, d);
        check("R7 no record without valid", d, 32'h0);
        probe(32'h0812_3456, 1'b1, 1'b1, 1'b1, ok);
        cfg_read(5'h10, d);
        check("R7 status after refusal", d, 32'h7);
        cfg_read(5'h14, d);
        check("R7 recorded address", d, 32'h0812_3456);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        logic ok;
        probe(32'h0850_0000, 1'b0, 1'b0, 1'b1, ok);
        check("R8 second refusal still refused", {31'b0, ok}, 32'h0);
        cfg_read(5'h10, d);
        check("R8 status unchanged", d, 32'h7);
        cfg_read(5'h14, d);
        check("R8 address unchanged", d, 32'h0812_3456);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        logic ok;
        cfg_write(5'h10, 32'hFFFF_FFFE);
        cfg_read(5'h10, d);
        check("R9 write without bit 0 keeps flag", {31'b0, d[0]}, 32'h1);
        cfg_write(5'h10, 32'h0000_0001);
        cfg_read(5'h10, d);
        check("R9 write with bit 0 clears flag", {31'b0, d[0]}, 32'h0);
        probe(32'h0900_0000, 1'b1, 1'b1, 1'b1, ok);
        check("R9 flag stays clear on allowed access", {31'b0, viol_flag}, 32'h0);
        cfg_write(5'h0C, 32'h4000_0000);
        probe(32'h087F_FFFC, 1'b1, 1'b0, 1'b1, ok);
        check("R4 kernel write refused where only kernel read set", {31'b0, ok}, 32'h0);
        cfg_read(5'h10, d);
        check("R7 new record after clear", d, 32'h3);
        cfg_read(5'h14, d);
        check("R7 new recorded address", d, 32'h087F_FFFC);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int w = 0; w < 4; w++) model[w] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regfile();
        t_mapping();
        t_edges();
        t_capture();
        t_sticky();
        t_clear();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule